// File: doc/BRIEF.md
# Two-Channel Block Transfer Engine

This block moves blocks of 8-bit or 16-bit units between addresses on a shared bus, so that the processor does not have to copy the data itself. Each channel is programmed in one cycle through a load strobe. The load supplies a source address, a destination address, a unit count and a mode byte, and it arms the channel. An armed channel raises a bus request when its selected request source is active. Once the bus is granted, the channel runs its unit. A dual-address unit reads the source and then writes the destination. A single-address unit is one bus cycle at the source address, with an acknowledge strobe so that the device supplies or takes the data directly.

In burst mode the channel keeps the bus until the whole block is done. In cycle-steal mode the channel gives the bus back after every unit and has to win it again. When the final unit completes, the channel disarms itself and pulses its completion interrupt for one cycle. When both channels are ready in the same cycle, channel 0 wins.

The bus handshake is simple. A cycle is presented with `busCyc` and completes on the clock edge at which `busReady` is high. The timing of the external memory is left to whatever sits behind that handshake.

Top module: `dma2ch`

## Requirements
- R1: While reset is low and after it is released with no channel armed, `busReq`, `busCyc`, `dack` and `irqDone` are all low.
- R2: A dual-address unit makes a read cycle at the source address and then a write cycle (`busWrite`=1) at the destination address. The write carries the data that was read. For 8-bit units only the low byte is written and `busWide` is low.
- R3: Mode bit 0 selects 16-bit units (`busWide` high). Mode bit 1 makes the source address advance and mode bit 2 makes the destination address advance after each unit, by 2 for 16-bit units and by 1 for 8-bit units. When a bit is clear, that address stays fixed.
- R4: A count loaded as N-1 gives exactly N units. After the last unit the channel disarms, so it makes no further requests, and `irqDone` for that channel is high for exactly one cycle.
- R5: With mode bit 5 set (burst), `busReq` stays high from the first request of a block until its last unit, and falls exactly once per block.
- R6: With mode bit 5 clear (cycle-steal), `busReq` falls after every unit, so it falls once per unit.
- R7: With mode bit 3 set (single-address), each unit is one bus cycle at the source address, and `busWrite` equals mode bit 4. The channel's `dack` bit is high only during that cycle, and at most one `dack` bit is high at a time.
- R8: Mode bits 7:6 select the request source: 0 is the active-low `dreqN` pin (level), 1 is `perReq` (level), 2 is a `swReq` pulse. A `swReq` pulse is held pending until the channel is granted. A source that is not selected has no effect. In cycle-steal mode each software pulse yields one unit.
- R9: When both channels want the bus in the same cycle, channel 0 is served first.
- R10: `busCyc` is high only while `busReq` and `busGrant` are both high. While a cycle waits with `busReady` low, the cycle, its address and its direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | NCH | Per-channel load strobe; loads the fields below and arms the channel |
| cfgSrc | input | AW | Source address to load |
| cfgDst | input | AW | Destination address to load |
| cfgCount | input | CW | Unit count minus one |
| cfgMode | input | 8 | Mode byte (bit fields as in R3, R5, R7, R8) |
| dreqN | input | NCH | Active-low request pins |
| perReq | input | NCH | Active-high requests from on-chip peripherals |
| swReq | input | NCH | Software trigger pulses |
| busReq | output | 1 | Bus request |
| busGrant | input | 1 | Bus grant |
| busCyc | output | 1 | A bus cycle is being presented |
| busWrite | output | 1 | Cycle direction, 1 for write |
| busWide | output | 1 | Cycle is 16 bits wide |
| busAddr | output | AW | Cycle address |
| busWdata | output | 16 | Write data |
| busRdata | input | 16 | Read data |
| busReady | input | 1 | Cycle completes at this edge |
| dack | output | NCH | Per-channel acknowledge for single-address cycles |
| irqDone | output | NCH | One-cycle block completion pulse per channel |

## Verification
The assertions check on every cycle the bus rules that hold in any state. A cycle only runs under a granted request. A cycle that is waiting for `busReady` keeps its address and direction. The acknowledges are exclusive and fall only inside bus cycles. Each completion interrupt lasts one cycle. Other behaviours depend on the programmed mode and on what came before, so only the bench's scenarios can show them. These are the data that lands at each address, the unit counts, how often the request falls in burst and cycle-steal modes, the disarming after the last unit, whether a source that is not selected is ignored, and which channel is served first.

// File: rtl/dma_pkg.sv
package dma_pkg;

  // Width of the channel index carried in the control strobes.
  localparam int CH_IDX_W = 4;

  // Request source codes (mode bits 7:6).
  localparam logic [1:0] SEL_PIN    = 2'd0;
  localparam logic [1:0] SEL_PERIPH = 2'd1;
  localparam logic [1:0] SEL_SOFT   = 2'd2;

  // Packed first field is the MSB: reqSel[7:6] burst[5] singleWrite[4]
  // singleAddr[3] dstInc[2] srcInc[1] wide[0].
  typedef struct packed {
    logic [1:0] reqSel;
    logic       burst;
    logic       singleWrite;
    logic       singleAddr;
    logic       dstInc;
    logic       srcInc;
    logic       wide;
  } chMode_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_READ,
    ST_WRITE,
    ST_SINGLE
  } dmaState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic [CH_IDX_W-1:0] chan;
    logic                useDst;
    logic                latchRd;
    logic                stepUnit;
  } dpCtl_t;

endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 26,
  parameter int CW  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NCH-1:0]           cfgLoad,
  input  logic [AW-1:0]            cfgSrc,
  input  logic [AW-1:0]            cfgDst,
  input  logic [CW-1:0]            cfgCount,
  input  chMode_t                  cfgMode,
  input  dpCtl_t                   ctl,
  input  logic [15:0]              busRdata,
  output logic [NCH-1:0]           armed,
  output logic [NCH-1:0]           lastUnit,
  output chMode_t [NCH-1:0]        modes,
  output logic [AW-1:0]            busAddr,
  output logic [15:0]              busWdata
);

  logic [NCH-1:0][AW-1:0] srcAll;
  logic [NCH-1:0][AW-1:0] dstAll;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [AW-1:0] srcR;
    logic [AW-1:0] dstR;
    logic [CW-1:0] cntR;
    chMode_t       modeR;
    logic          armR;
    logic [AW-1:0] stepVal;
    logic          mine;

    assign stepVal = modeR.wide ? AW'(2) : AW'(1);
    assign mine    = ctl.stepUnit && (ctl.chan == CH_IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcR  <= '0;
        dstR  <= '0;
        cntR  <= '0;
        modeR <= '0;
        armR  <= 1'b0;
      end else if (cfgLoad[g]) begin
        srcR  <= cfgSrc;
        dstR  <= cfgDst;
        cntR  <= cfgCount;
        modeR <= cfgMode;
        armR  <= 1'b1;
      end else if (mine) begin
        if (modeR.srcInc) srcR <= srcR + stepVal;
        if (modeR.dstInc) dstR <= dstR + stepVal;
        if (cntR == '0) armR <= 1'b0;
        else            cntR <= cntR - CW'(1);
      end
    end

    assign srcAll[g]   = srcR;
    assign dstAll[g]   = dstR;
    assign modes[g]    = modeR;
    assign armed[g]    = armR;
    assign lastUnit[g] = (cntR == '0);
  end

  // Select the serviced channel's address and width.
  logic    curWide;
  always_comb begin
    busAddr = '0;
    curWide = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (ctl.chan == CH_IDX_W'(i)) begin
        busAddr = ctl.useDst ? dstAll[i] : srcAll[i];
        curWide = modes[i].wide;
      end
    end
  end

  // Holding register between the read and write halves of a unit.
  logic [15:0] dataR;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataR <= '0;
    else if (ctl.latchRd) dataR <= curWide ? busRdata : {8'h00, busRdata[7:0]};
  end

  assign busWdata = dataR;

endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    cfgLoad,
  input  logic [NCH-1:0]    armed,
  input  logic [NCH-1:0]    lastUnit,
  input  chMode_t [NCH-1:0] modes,
  input  logic [NCH-1:0]    dreqN,
  input  logic [NCH-1:0]    perReq,
  input  logic [NCH-1:0]    swReq,
  input  logic              busGrant,
  input  logic              busReady,
  output dpCtl_t            ctl,
  output logic              busReq,
  output logic              busCyc,
  output logic              busWrite,
  output logic              busWide,
  output logic [NCH-1:0]    dack,
  output logic [NCH-1:0]    irqDone
);

  dmaState_t           state;
  logic [CH_IDX_W-1:0] cur;
  logic [NCH-1:0]      swPend;
  logic [NCH-1:0]      want;
  logic [CH_IDX_W-1:0] winner;
  logic                anyWant;
  chMode_t             curMode;
  logic                curLast;
  logic                unitEnd;

  // Request qualification and fixed-priority pick (lowest index wins).
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      logic live;
      case (modes[i].reqSel)
        SEL_PIN:    live = ~dreqN[i];
        SEL_PERIPH: live = perReq[i];
        SEL_SOFT:   live = swPend[i];
        default:    live = 1'b0;
      endcase
      want[i] = armed[i] && live;
    end
    anyWant = |want;
    winner  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (want[i]) winner = CH_IDX_W'(i);
    end
    curMode = '0;
    curLast = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (cur == CH_IDX_W'(i)) begin
        curMode = modes[i];
        curLast = lastUnit[i];
      end
    end
  end

  assign unitEnd  = ((state == ST_WRITE) || (state == ST_SINGLE)) && busReady;
  assign busReq   = (state != ST_IDLE);
  assign busCyc   = (state == ST_READ) || (state == ST_WRITE) || (state == ST_SINGLE);
  assign busWrite = (state == ST_WRITE) || ((state == ST_SINGLE) && curMode.singleWrite);
  assign busWide  = busCyc && curMode.wide;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      dack[i] = (state == ST_SINGLE) && (cur == CH_IDX_W'(i));
    end
  end

  assign ctl.chan     = cur;
  assign ctl.useDst   = (state == ST_WRITE);
  assign ctl.latchRd  = (state == ST_READ) && busReady;
  assign ctl.stepUnit = unitEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cur     <= '0;
      irqDone <= '0;
    end else begin
      irqDone <= '0;
      case (state)
        ST_IDLE: begin
          if (anyWant) begin
            cur   <= winner;
            state <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (busGrant) state <= curMode.singleAddr ? ST_SINGLE : ST_READ;
        end
        ST_READ: begin
          if (busReady) state <= ST_WRITE;
        end
        default: begin
          if (unitEnd) begin
            if (curLast) begin
              state <= ST_IDLE;
              for (int i = 0; i < NCH; i++) begin
                if (cur == CH_IDX_W'(i)) irqDone[i] <= 1'b1;
              end
            end else if (curMode.burst) begin
              state <= curMode.singleAddr ? ST_SINGLE : ST_READ;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  // Software triggers are held until the channel wins the bus.
  for (genvar g = 0; g < NCH; g++) begin : g_pend
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        swPend[g] <= 1'b0;
      end else if (cfgLoad[g]) begin
        swPend[g] <= 1'b0;
      end else if (swReq[g] && armed[g] && (modes[g].reqSel == SEL_SOFT)) begin
        swPend[g] <= 1'b1;
      end else if ((state == ST_REQ) && busGrant && (cur == CH_IDX_W'(g))) begin
        swPend[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dma2ch.sv
module dma2ch
  import dma_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 26,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] cfgLoad,
  input  logic [AW-1:0]  cfgSrc,
  input  logic [AW-1:0]  cfgDst,
  input  logic [CW-1:0]  cfgCount,
  input  logic [7:0]     cfgMode,
  input  logic [NCH-1:0] dreqN,
  input  logic [NCH-1:0] perReq,
  input  logic [NCH-1:0] swReq,
  output logic           busReq,
  input  logic           busGrant,
  output logic           busCyc,
  output logic           busWrite,
  output logic           busWide,
  output logic [AW-1:0]  busAddr,
  output logic [15:0]    busWdata,
  input  logic [15:0]    busRdata,
  input  logic           busReady,
  output logic [NCH-1:0] dack,
  output logic [NCH-1:0] irqDone
);

  dpCtl_t            ctl;
  logic [NCH-1:0]    armed;
  logic [NCH-1:0]    lastUnit;
  chMode_t [NCH-1:0] modes;

  dma_datapath #(.NCH(NCH), .AW(AW), .CW(CW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgLoad  (cfgLoad),
    .cfgSrc   (cfgSrc),
    .cfgDst   (cfgDst),
    .cfgCount (cfgCount),
    .cfgMode  (chMode_t'(cfgMode)),
    .ctl      (ctl),
    .busRdata (busRdata),
    .armed    (armed),
    .lastUnit (lastUnit),
    .modes    (modes),
    .busAddr  (busAddr),
    .busWdata (busWdata)
  );

  dma_control #(.NCH(NCH)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgLoad  (cfgLoad),
    .armed    (armed),
    .lastUnit (lastUnit),
    .modes    (modes),
    .dreqN    (dreqN),
    .perReq   (perReq),
    .swReq    (swReq),
    .busGrant (busGrant),
    .busReady (busReady),
    .ctl      (ctl),
    .busReq   (busReq),
    .busCyc   (busCyc),
    .busWrite (busWrite),
    .busWide  (busWide),
    .dack     (dack),
    .irqDone  (irqDone)
  );

endmodule

// File: rtl/dma2ch_chk.sv
module dma2ch_chk #(
  parameter int NCH = 2,
  parameter int AW  = 26
) (
  input logic           clk,
  input logic           rstN,
  input logic           busReq,
  input logic           busGrant,
  input logic           busCyc,
  input logic           busWrite,
  input logic [AW-1:0]  busAddr,
  input logic           busReady,
  input logic [NCH-1:0] dack,
  input logic [NCH-1:0] irqDone
);

  // R1: everything quiet while reset is held.
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!busReq && !busCyc && (dack == '0) && (irqDone == '0))
        else $error("R1 outputs active during reset");
    end
  end

  p_cyc_granted_r10: assert property (@(posedge clk) disable iff (!rstN)
    busCyc |-> (busReq && busGrant))
    else $error("R10 bus cycle without grant");

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busCyc && !busReady) |=> (busCyc && $stable(busAddr) && $stable(busWrite)))
    else $error("R10 waiting cycle changed");

  p_dack_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dack))
    else $error("R7 more than one acknowledge");

  p_dack_in_cycle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|dack) |-> busCyc)
    else $error("R7 acknowledge outside a bus cycle");

  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqDone))
    else $error("R4 two completion pulses at once");

  p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|irqDone) |=> (irqDone == '0))
    else $error("R4 completion pulse longer than one cycle");

endmodule

bind dma2ch dma2ch_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busReq   (busReq),
  .busGrant (busGrant),
  .busCyc   (busCyc),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busReady (busReady),
  .dack     (dack),
  .irqDone  (irqDone)
);

// File: tb/dma2ch_test.sv
module dma2ch_test;

  localparam int NCH = 2;
  localparam int AW  = 26;
  localparam int CW  = 16;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] cfgLoad = '0;
  logic [AW-1:0]  cfgSrc = '0;
  logic [AW-1:0]  cfgDst = '0;
  logic [CW-1:0]  cfgCount = '0;
  logic [7:0]     cfgMode = '0;
  logic [NCH-1:0] dreqN = '1;
  logic [NCH-1:0] perReq = '0;
  logic [NCH-1:0] swReq = '0;
  logic           busReq;
  logic           busGrant = 1'b0;
  logic           busCyc;
  logic           busWrite;
  logic           busWide;
  logic [AW-1:0]  busAddr;
  logic [15:0]    busWdata;
  logic [15:0]    busRdata = '0;
  logic           busReady = 1'b0;
  logic [NCH-1:0] dack;
  logic [NCH-1:0] irqDone;

  always #2 clk = ~clk;

  dma2ch #(.NCH(NCH), .AW(AW), .CW(CW)) uut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgSrc(cfgSrc), .cfgDst(cfgDst),
    .cfgCount(cfgCount), .cfgMode(cfgMode), .dreqN(dreqN), .perReq(perReq),
    .swReq(swReq), .busReq(busReq), .busGrant(busGrant), .busCyc(busCyc),
    .busWrite(busWrite), .busWide(busWide), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busReady(busReady), .dack(dack), .irqDone(irqDone)
  );

  int checks = 0;
  int errors = 0;

  // Bus model state and event counters.
  logic [7:0] mem    [256];
  logic [7:0] expMem [256];
  logic       waitMode = 1'b0;
  logic       waitTog = 1'b0;
  logic       prevReq = 1'b0;
  logic       seenFirst = 1'b1;
  logic [7:0] firstAddr = '0;
  int         dualUnits = 0;
  int         sglUnits = 0;
  int         sglWrites = 0;
  int         reqRises = 0;
  int         reqFalls = 0;
  int         irqCnt [2] = '{0, 0};
  logic [7:0] sglAddr [8];

  // vector: mode[40:33] count[32:17] src[16:9] dst[8:1] wait[0]
  localparam logic [40:0] VECS [0:4] = '{
    {8'hA6, 16'd3, 8'h10, 8'h80, 1'b0},
    {8'hA7, 16'd2, 8'h20, 8'h90, 1'b1},
    {8'hA4, 16'd2, 8'h30, 8'hA0, 1'b0},
    {8'hA3, 16'd1, 8'h40, 8'hB0, 1'b1},
    {8'hA6, 16'd0, 8'h50, 8'hC0, 1'b0}
  };

  // Responder: grant, memory, ready and counters, all at the falling edge.
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    forever begin
      logic [7:0] a;
      logic [7:0] a1;
      logic       rdy;
      @(negedge clk);
      busGrant = busReq;
      if (busCyc) begin
        if (waitMode) begin
          rdy = waitTog;
          waitTog = ~waitTog;
        end else begin
          rdy = 1'b1;
        end
      end else begin
        rdy = 1'b0;
      end
      busReady = rdy;
      a  = busAddr[7:0];
      a1 = a + 8'd1;
      busRdata = {mem[a1], mem[a]};
      if (busCyc && !seenFirst) begin
        firstAddr = a;
        seenFirst = 1'b1;
      end
      if (busCyc && rdy) begin
        if (|dack) begin
          if (sglUnits < 8) sglAddr[sglUnits] = a;
          sglUnits++;
          if (busWrite) sglWrites++;
        end else if (busWrite) begin
          dualUnits++;
          mem[a] = busWdata[7:0];
          if (busWide) mem[a1] = busWdata[15:8];
        end
      end
      if (busReq && !prevReq) reqRises++;
      if (!busReq && prevReq) reqFalls++;
      prevReq = busReq;
      if (irqDone[0]) irqCnt[0]++;
      if (irqDone[1]) irqCnt[1]++;
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic loadCh(input int ch, input logic [7:0] mode, input logic [15:0] cnt,
                        input logic [7:0] src, input logic [7:0] dst);
    @(negedge clk);
    cfgMode  = mode;
    cfgCount = cnt;
    cfgSrc   = AW'(src);
    cfgDst   = AW'(dst);
    cfgLoad  = NCH'(1) << ch;
    @(negedge clk);
    cfgLoad  = '0;
  endtask

  task automatic swPulse(input logic [NCH-1:0] m);
    @(negedge clk);
    swReq = m;
    @(negedge clk);
    swReq = '0;
  endtask

  task automatic waitIrq(input int ch, input int base);
    int n = 0;
    while (irqCnt[ch] == base && n < 3000) begin
      @(negedge clk);
      n++;
    end
    idle(3);
  endtask

  function automatic int memDiff();
    int d = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== expMem[i]) d++;
    return d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, during and after reset.
    idle(3);
    check("R1", "busReq in reset", busReq, 0);
    check("R1", "busCyc in reset", busCyc, 0);
    @(negedge clk);
    rstN = 1'b1;
    idle(5);
    check("R1", "busReq idle", busReq, 0);
    check("R1", "dack/irq idle", {dack, irqDone}, 0);

    // Table of burst block copies on channel 0 under a software trigger (R2 R3 R4 R5).
    for (int v = 0; v < 5; v++) begin
      logic [40:0] e;
      logic [7:0]  md;
      logic [15:0] cn;
      logic [7:0]  s;
      logic [7:0]  d;
      int u0, f0, i0, step;
      e  = VECS[v];
      md = e[40:33];
      cn = e[32:17];
      s  = e[16:9];
      d  = e[8:1];
      waitMode = e[0];
      step = md[0] ? 2 : 1;
      for (int i = 0; i < 256; i++) expMem[i] = mem[i];
      for (int u = 0; u <= int'(cn); u++) begin
        logic [7:0] sa;
        logic [7:0] da;
        sa = s + (md[1] ? 8'(u * step) : 8'd0);
        da = d + (md[2] ? 8'(u * step) : 8'd0);
        expMem[da] = expMem[sa];
        if (md[0]) expMem[8'(da + 8'd1)] = expMem[8'(sa + 8'd1)];
      end
      u0 = dualUnits; f0 = reqFalls; i0 = irqCnt[0];
      loadCh(0, md, cn, s, d);
      swPulse(2'b01);
      waitIrq(0, i0);
      check("R2", $sformatf("vector %0d memory mismatches", v), memDiff(), 0);
      check("R4", $sformatf("vector %0d unit count", v), dualUnits - u0, int'(cn) + 1);
      check("R5", $sformatf("vector %0d request falls", v), reqFalls - f0, 1);
      check("R4", $sformatf("vector %0d irq pulses", v), irqCnt[0] - i0, 1);
    end
    waitMode = 1'b0;

    // R7 R6 R8: single-address, cycle-steal, pin request held low on channel 1.
    begin
      int s0, w0, f0, i0, r0;
      s0 = sglUnits; w0 = sglWrites; f0 = reqFalls; i0 = irqCnt[1];
      loadCh(1, 8'h1B, 16'd2, 8'h70, 8'h00);
      @(negedge clk);
      dreqN[1] = 1'b0;
      waitIrq(1, i0);
      check("R7", "single units", sglUnits - s0, 3);
      check("R7", "single write direction", sglWrites - w0, 3);
      check("R7", "single addr unit0", sglAddr[s0], 8'h70);
      check("R3", "single addr unit2 steps by 2", sglAddr[s0 + 2], 8'h74);
      check("R6", "request falls per unit", reqFalls - f0, 3);
      check("R4", "channel 1 irq", irqCnt[1] - i0, 1);
      r0 = reqRises;
      idle(20);
      check("R4", "disarmed, pin still low, no request", reqRises - r0, 0);
      dreqN[1] = 1'b1;
    end

    // R8: unselected sources are ignored; the selected peripheral line runs it.
    begin
      int r0, i0;
      loadCh(1, 8'h66, 16'd1, 8'h60, 8'hD0);
      r0 = reqRises; i0 = irqCnt[1];
      @(negedge clk);
      dreqN[1] = 1'b0;
      swPulse(2'b10);
      idle(10);
      dreqN[1] = 1'b1;
      idle(2);
      check("R8", "pin and software ignored when peripheral selected", reqRises - r0, 0);
      for (int i = 0; i < 256; i++) expMem[i] = mem[i];
      expMem[8'hD0] = mem[8'h60];
      expMem[8'hD1] = mem[8'h61];
      @(negedge clk);
      perReq[1] = 1'b1;
      waitIrq(1, i0);
      perReq[1] = 1'b0;
      check("R8", "peripheral-driven copy", memDiff(), 0);
      check("R8", "peripheral irq", irqCnt[1] - i0, 1);
    end

    // R8 R6: software cycle-steal needs one pulse per unit.
    begin
      int u0, i0;
      loadCh(0, 8'h86, 16'd1, 8'h05, 8'hF0);
      u0 = dualUnits; i0 = irqCnt[0];
      swPulse(2'b01);
      idle(30);
      check("R8", "one unit per software pulse", dualUnits - u0, 1);
      check("R6", "block not yet complete", irqCnt[0] - i0, 0);
      swPulse(2'b01);
      waitIrq(0, i0);
      check("R8", "second pulse finishes block", dualUnits - u0, 2);
    end

    // R9: simultaneous software triggers, channel 0 first.
    begin
      int i0, i1;
      loadCh(0, 8'h86, 16'd0, 8'h11, 8'hE0);
      loadCh(1, 8'h86, 16'd0, 8'h12, 8'hE8);
      i0 = irqCnt[0]; i1 = irqCnt[1];
      @(negedge clk);
      seenFirst = 1'b0;
      swPulse(2'b11);
      waitIrq(1, i1);
      check("R9", "first bus address from channel 0", firstAddr, 8'h11);
      check("R9", "both channels complete", (irqCnt[0] - i0) + (irqCnt[1] - i1), 2);
      check("R2", "channel 0 byte copied", mem[8'hE0], mem[8'h11]);
      check("R2", "channel 1 byte copied", mem[8'hE8], mem[8'h12]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule